// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block chooses which way of a set-associative cache should receive the next incoming line. For every lookup the cache presents the set being accessed, whether the lookup hit and in which way, and the valid bits of that set's ways. The unit answers with a victim way number. The answer is combinational from the current state and the presented set. The unit then updates its per-set bookkeeping on the clock edge that accepts the access. Tags, data and refill sequencing stay with the surrounding cache.

The replacement algorithm is fixed when the block is elaborated. The choices are exact least-recently-used ordering, a not-recently-used scheme with one reference bit per way, first-in-first-out with one pointer per set, and a pseudo-random pick from a shared shift register. Only the storage that the chosen algorithm needs is built. In every mode a set that still has an empty way fills that way first, and the algorithm is consulted only once the set is full.

Top module: `repl_unit`

## Requirements
- R1: When any bit of `validMask` is 0, `victimWay` is the lowest-numbered way whose valid bit is 0, whatever the policy.
- R2: With `accValid` low, no state changes: for an unchanged set and mask, `victimWay` stays the same across clock edges.
- R3: In LRU mode, reset ranks way 0 as most recent and way NUM_WAYS-1 as least recent, and for a full set `victimWay` is the least recently used way.
- R4: In LRU mode, an accepted hit (way `accHitWay`) or miss (way `victimWay`) makes that way most recent, and only the ways that were more recent than it age by one.
- R5: In NRU mode, each way has one reference bit that is cleared by reset and set by a hit or fill to that way. For a full set, the victim is the lowest-numbered way whose bit is 0.
- R6: In NRU mode, if setting a reference bit would leave all bits of the set at 1, every other bit of that set is cleared.
- R7: In FIFO mode, each set's pointer resets to way 0, supplies the victim of a full set, and advances by one with wrap to 0 on each miss to a full set. A miss that fills an empty way does not advance it.
- R8: In FIFO mode, hits leave the pointer unchanged.
- R9: In random mode, a 16-bit shift register seeded with 0xACE1 shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. It advances once per accepted miss, including fills into empty ways, and a full set's victim is its value modulo NUM_WAYS.
- R10: State is kept per set: accesses to one set never change the victim of another set (random mode excepted, whose register is shared).
- R11: A reset restores the initial state of every set, whatever accesses came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| accValid | input | 1 | An access is presented this cycle |
| accSet | input | $clog2(NUM_SETS) | Set index of the access |
| accHit | input | 1 | 1 for a hit, 0 for a miss |
| accHitWay | input | $clog2(NUM_WAYS) | Way that hit, used when accHit is 1 |
| validMask | input | NUM_WAYS | Valid bits of the ways of set accSet |
| victimWay | output | $clog2(NUM_WAYS) | Way to fill for this set |

## Verification
On every cycle the assertions check four things. They check the empty-way precedence and range of the victim. They check that the victim holds while no access is presented. They check that a way just touched in LRU or NRU mode is never the next victim of that set. They check the FIFO pointer's hold-on-hit and step-on-full-miss, and that the random pick moves only on misses. The exact LRU age ordering, the NRU clear-on-saturation, the FIFO wrap, the register sequence, the independence of sets and the return to initial state after a later reset are shown only by the bench. It drives one access trace into four instances, one per policy, and compares each victim against values worked out by hand.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_NRU  = 2'd1,
    POL_FIFO = 2'd2,
    POL_RAND = 2'd3
  } policy_e;

  // strobes from control to state datapath
  typedef struct packed {
    logic hitTouch;   // accepted hit: refresh accHitWay
    logic fillTouch;  // accepted miss: refresh the chosen victim
    logic evict;      // miss to a set with no empty way
    logic stepRand;   // advance the random source
  } strobe_t;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/repl_ctrl.sv
module repl_ctrl #(
  parameter int NUM_WAYS = 4
) (
  input  logic                  accValid,
  input  logic                  accHit,
  input  logic [NUM_WAYS-1:0]   validMask,
  output repl_pkg::strobe_t     strb
);
  logic setFull;

  assign setFull = &validMask;

  always_comb begin
    strb.hitTouch  = accValid & accHit;
    strb.fillTouch = accValid & ~accHit;
    strb.evict     = accValid & ~accHit & setFull;
    strb.stepRand  = accValid & ~accHit;
  end
endmodule

// File: rtl/repl_state.sv
module repl_state #(
  parameter int               NUM_SETS = 4,
  parameter int               NUM_WAYS = 4,
  parameter repl_pkg::policy_e POLICY  = repl_pkg::POL_LRU,
  localparam int              SET_W    = $clog2(NUM_SETS),
  localparam int              WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  repl_pkg::strobe_t    strb,
  input  logic [SET_W-1:0]     accSet,
  input  logic [WAY_W-1:0]     accHitWay,
  input  logic [NUM_WAYS-1:0]  validMask,
  output logic [WAY_W-1:0]     victimWay
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  logic             anyFree;
  logic [WAY_W-1:0] firstFree;
  logic [WAY_W-1:0] polVictim;
  logic [WAY_W-1:0] touchWay;
  logic             touch;

  always_comb begin
    anyFree   = 1'b0;
    firstFree = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!validMask[w]) begin
        anyFree   = 1'b1;
        firstFree = WAY_W'(w);
      end
    end
  end

  assign victimWay = anyFree ? firstFree : polVictim;
  assign touch     = strb.hitTouch | strb.fillTouch;
  assign touchWay  = strb.hitTouch ? accHitWay : victimWay;

  generate
    if (POLICY == repl_pkg::POL_LRU) begin : g_lru
      // rank 0 = most recent, LAST_WAY = least recent
      logic [WAY_W-1:0] rank [NUM_SETS][NUM_WAYS];
      logic [WAY_W-1:0] touchRank;

      assign touchRank = rank[accSet][touchWay];

      always_comb begin
        polVictim = '0;
        for (int w = 0; w < NUM_WAYS; w++)
          if (rank[accSet][w] == LAST_WAY) polVictim = WAY_W'(w);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
              rank[s][w] <= WAY_W'(w);
        end else if (touch) begin
          for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touchWay)
              rank[accSet][w] <= '0;
            else if (rank[accSet][w] < touchRank)
              rank[accSet][w] <= rank[accSet][w] + 1'b1;
          end
        end
      end
    end else if (POLICY == repl_pkg::POL_NRU) begin : g_nru
      logic [NUM_WAYS-1:0] refBits [NUM_SETS];
      logic [NUM_WAYS-1:0] touchHot;
      logic [NUM_WAYS-1:0] nextBits;

      always_comb begin
        touchHot = '0;
        touchHot[touchWay] = 1'b1;
        nextBits = refBits[accSet] | touchHot;
        if (&nextBits) nextBits = touchHot;
      end

      always_comb begin
        polVictim = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--)
          if (!refBits[accSet][w]) polVictim = WAY_W'(w);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_SETS; s++) refBits[s] <= '0;
        end else if (touch) begin
          refBits[accSet] <= nextBits;
        end
      end
    end else if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] headPtr [NUM_SETS];

      assign polVictim = headPtr[accSet];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_SETS; s++) headPtr[s] <= '0;
        end else if (strb.evict) begin
          headPtr[accSet] <= (headPtr[accSet] == LAST_WAY) ? '0
                                                            : headPtr[accSet] + 1'b1;
        end
      end
    end else begin : g_rand
      logic [15:0] lfsr;

      assign polVictim = WAY_W'(lfsr % 16'(NUM_WAYS));

      always_ff @(posedge clk) begin
        if (!rst_n)
          lfsr <= repl_pkg::LFSR_SEED;
        else if (strb.stepRand)
          lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
    end
  endgenerate
endmodule

// File: rtl/repl_unit.sv
module repl_unit #(
  parameter int                NUM_SETS = 4,
  parameter int                NUM_WAYS = 4,
  parameter repl_pkg::policy_e POLICY   = repl_pkg::POL_LRU,
  localparam int               SET_W    = $clog2(NUM_SETS),
  localparam int               WAY_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accValid,
  input  logic [SET_W-1:0]    accSet,
  input  logic                accHit,
  input  logic [WAY_W-1:0]    accHitWay,
  input  logic [NUM_WAYS-1:0] validMask,
  output logic [WAY_W-1:0]    victimWay
);
  repl_pkg::strobe_t strb;

  repl_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .accValid (accValid),
    .accHit   (accHit),
    .validMask(validMask),
    .strb     (strb)
  );

  repl_state #(
    .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS),
    .POLICY  (POLICY)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .accSet   (accSet),
    .accHitWay(accHitWay),
    .validMask(validMask),
    .victimWay(victimWay)
  );
endmodule

// File: rtl/repl_unit_chk.sv
module repl_unit_chk #(
  parameter int                NUM_SETS = 4,
  parameter int                NUM_WAYS = 4,
  parameter repl_pkg::policy_e POLICY   = repl_pkg::POL_LRU,
  localparam int               SET_W    = $clog2(NUM_SETS),
  localparam int               WAY_W    = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                accValid,
  input logic [SET_W-1:0]    accSet,
  input logic                accHit,
  input logic [WAY_W-1:0]    accHitWay,
  input logic [NUM_WAYS-1:0] validMask,
  input logic [WAY_W-1:0]    victimWay
);
  logic             lowerAllValid;
  logic             full;
  logic [WAY_W-1:0] touched;

  assign full    = &validMask;
  assign touched = accHit ? accHitWay : victimWay;

  always_comb begin
    lowerAllValid = 1'b1;
    for (int w = 0; w < NUM_WAYS; w++)
      if (WAY_W'(w) < victimWay && !validMask[w]) lowerAllValid = 1'b0;
  end

  assert_free_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> (!validMask[victimWay] && lowerAllValid));

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(victimWay) < NUM_WAYS);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!accValid && full) |=>
      (!(accSet == $past(accSet) && full) || victimWay == $past(victimWay)));

  // R4 (LRU) and R5 (NRU): a way just used cannot be the next victim of its set
  assert_touched_not_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((POLICY == repl_pkg::POL_LRU || POLICY == repl_pkg::POL_NRU) && NUM_WAYS > 1
      && accValid && full) |=>
      (!(accSet == $past(accSet) && full) || victimWay != $past(touched)));

  assert_fifo_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == repl_pkg::POL_FIFO && accValid && !accHit && full) |=>
      (!(accSet == $past(accSet) && full) ||
       victimWay == (($past(victimWay) == WAY_W'(NUM_WAYS - 1)) ? '0
                                                                : $past(victimWay) + 1'b1)));

  assert_fifo_hit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == repl_pkg::POL_FIFO && accValid && accHit && full) |=>
      (!(accSet == $past(accSet) && full) || victimWay == $past(victimWay)));

  assert_rand_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == repl_pkg::POL_RAND && !(accValid && !accHit) && full) |=>
      (!full || victimWay == $past(victimWay)));
endmodule

bind repl_unit repl_unit_chk #(
  .NUM_SETS(NUM_SETS),
  .NUM_WAYS(NUM_WAYS),
  .POLICY  (POLICY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accValid (accValid),
  .accSet   (accSet),
  .accHit   (accHit),
  .accHitWay(accHitWay),
  .validMask(validMask),
  .victimWay(victimWay)
);

// File: tb/repl_unit_tb.sv
module repl_unit_tb;
  localparam int NS = 4;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       accValid = 1'b0;
  logic [1:0] accSet = '0;
  logic       accHit = 1'b0;
  logic [1:0] accHitWay = '0;
  logic [3:0] validMask = 4'hF;
  logic [1:0] vLru, vNru, vFifo, vRand;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsrModel = 16'hACE1;

  always #5 clk = ~clk;

  repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(repl_pkg::POL_LRU)) u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accHitWay(accHitWay), .validMask(validMask), .victimWay(vLru));
  repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(repl_pkg::POL_NRU)) u_dut_nru (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accHitWay(accHitWay), .validMask(validMask), .victimWay(vNru));
  repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(repl_pkg::POL_FIFO)) u_dut_fifo (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accHitWay(accHitWay), .validMask(validMask), .victimWay(vFifo));
  repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .POLICY(repl_pkg::POL_RAND)) u_dut_rand (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accHitWay(accHitWay), .validMask(validMask), .victimWay(vRand));

  typedef struct packed {
    logic [1:0] set;
    logic       hit;
    logic [1:0] way;
    logic [1:0] expLru;
    logic [1:0] expNru;
    logic [1:0] expFifo;
  } vec_t;

  // full-set trace; expected victims are those seen before each access is accepted
  localparam vec_t VECS [11] = '{
    '{2'd0, 1'b0, 2'd0, 2'd3, 2'd0, 2'd0},
    '{2'd0, 1'b1, 2'd1, 2'd2, 2'd1, 2'd1},
    '{2'd0, 1'b0, 2'd0, 2'd2, 2'd2, 2'd1},
    '{2'd0, 1'b1, 2'd3, 2'd0, 2'd3, 2'd2},
    '{2'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2},
    '{2'd1, 1'b0, 2'd0, 2'd3, 2'd0, 2'd0},
    '{2'd0, 1'b1, 2'd0, 2'd1, 2'd1, 2'd3},
    '{2'd0, 1'b0, 2'd0, 2'd1, 2'd1, 2'd3},
    '{2'd0, 1'b0, 2'd0, 2'd2, 2'd2, 2'd0},
    '{2'd0, 1'b1, 2'd2, 2'd3, 2'd0, 2'd1},
    '{2'd1, 1'b1, 2'd3, 2'd2, 2'd1, 2'd1}
  };

  function automatic logic [15:0] lfsrNext(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] s, input logic h,
                       input logic [1:0] w, input logic [3:0] m);
    @(negedge clk);
    accValid = v; accSet = s; accHit = h; accHitWay = w; validMask = m;
    #1;
  endtask

  task automatic accept();
    if (accValid && !accHit) lfsrModel = lfsrNext(lfsrModel);
    @(posedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; accValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lfsrModel = 16'hACE1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // R11 / R3 / R5 / R7 / R9: initial state seen on an untouched set
    drive(1'b0, 2'd2, 1'b0, 2'd0, 4'hF);
    check(vLru,  3, "R3 reset LRU victim");
    check(vNru,  0, "R5 reset NRU victim");
    check(vFifo, 0, "R7 reset FIFO victim");
    check(vRand, int'(lfsrModel % 4), "R9 reset random victim");

    // R3 R4 R5 R6 R7 R8 R9 R10: table walk
    for (int i = 0; i < 11; i++) begin
      drive(1'b1, VECS[i].set, VECS[i].hit, VECS[i].way, 4'hF);
      check(vLru,  VECS[i].expLru,  $sformatf("R3/R4 LRU vec %0d", i));
      check(vNru,  VECS[i].expNru,  $sformatf("R5/R6 NRU vec %0d", i));
      check(vFifo, VECS[i].expFifo, $sformatf("R7/R8 FIFO vec %0d", i));
      check(vRand, int'(lfsrModel % 4), $sformatf("R9 random vec %0d", i));
      accept();
    end

    // R2: idle cycles leave every victim of set 0 alone
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'hF);
    repeat (3) accept();
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'hF);
    check(vLru,  3, "R2 idle LRU");
    check(vNru,  0, "R2 idle NRU");
    check(vFifo, 1, "R2 idle FIFO");
    check(vRand, int'(lfsrModel % 4), "R2 idle random");

    // R1: empty ways win over every policy
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'b1010);
    check(vLru, 0, "R1 LRU mask 1010");
    check(vNru, 0, "R1 NRU mask 1010");
    check(vFifo, 0, "R1 FIFO mask 1010");
    check(vRand, 0, "R1 random mask 1010");
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'b0111);
    check(vLru, 3, "R1 LRU mask 0111");
    check(vFifo, 3, "R1 FIFO mask 0111");
    check(vRand, 3, "R1 random mask 0111");

    // R1 R4 R7 R9: fill into empty way 2 of fresh set 2
    drive(1'b1, 2'd2, 1'b0, 2'd0, 4'b0011);
    check(vNru, 2, "R1 fill way NRU");
    accept();
    drive(1'b0, 2'd2, 1'b0, 2'd0, 4'hF);
    check(vLru,  3, "R4 LRU after fill");
    check(vNru,  0, "R5 NRU after fill");
    check(vFifo, 0, "R7 FIFO no step on empty-way fill");
    check(vRand, int'(lfsrModel % 4), "R9 random steps on fill");
    drive(1'b1, 2'd2, 1'b1, 2'd3, 4'hF);
    accept();
    drive(1'b0, 2'd2, 1'b0, 2'd0, 4'hF);
    check(vLru, 1, "R4 LRU after hit way3");
    // R10: set 0 untouched by set 2 traffic
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'hF);
    check(vLru,  3, "R10 LRU set0 kept");
    check(vNru,  0, "R10 NRU set0 kept");
    check(vFifo, 1, "R10 FIFO set0 kept");

    // R11: a later reset restores everything
    doReset();
    drive(1'b0, 2'd0, 1'b0, 2'd0, 4'hF);
    check(vLru,  3, "R11 LRU after reset");
    check(vNru,  0, "R11 NRU after reset");
    check(vFifo, 0, "R11 FIFO after reset");
    check(vRand, 1, "R11 random after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule